// File: doc/BRIEF.md
# Programmable Fiducial Pulse Generator

The block produces a periodic marker pulse that is synchronous to the bunch clock, which runs at about 9.4 MHz. A free-running counter advances once per bunch clock and raises the marker for exactly one clock when it reaches its terminal count. With the default setting the marker repeats every 120 clocks, which is one pulse per beam-crossing cycle. A single marker lasts one clock period, about 106 ns.

The period is double-buffered. Software writes a 9-bit period into a staging register, and a separate load command moves it into the active stage and restarts the count. A source select routes either the internal marker or a synchronized external marker to the registered output, and the status output shows which source is routed. A write to the soft-reset location returns the whole block to its reset state.

Register map, written with `wr_en_i` high for one clock: address 0 is the staging period (data bits 8..0), address 1 is the load command (data bit 0 = 1 loads), address 2 is the source select (data bit 0: 0 internal, 1 external), and address 3 is soft reset (any data).

Top module: `fid_gen`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, `fid_o` and `status_o` are 0. The staging and active periods both reset to 120.
- R2: With the default period of 120 and the internal source, `fid_o` is high after edges 120, 240, and so on, counted from reset release (or from the edge of a soft reset or a load).
- R3: For a period P of 2 or more, each internal marker is high for exactly one clock and low for the P-1 clocks between markers.
- R4: A write to address 0 alone does not change the period or the phase of the running marker.
- R5: A write to address 1 with data bit 0 = 1, sampled at edge E, copies the staging period P into the active stage and restarts the count. `fid_o` is 0 after edge E and is next high after edges E+P, E+2P, and so on.
- R6: A write to address 1 with data bit 0 = 0 has no effect on the period or the phase.
- R7: A write to address 2 at edge S sets `status_o` to data bit 0 after edge S. From edge S+1 on, `fid_o` follows the newly selected source. `status_o` changes only through a write to address 2 or a soft reset.
- R8: While the external source is selected, `fid_o` after edge n equals `ext_fid_i` as sampled at edge n-2. The path is a two-flop synchronizer followed by the output register.
- R9: A loaded period of 0 or 1 keeps the internal marker permanently high. `fid_o` is 0 after the load edge and 1 after every following edge.
- R10: Any write to address 3 returns the block to its reset state. This covers the staging period, active period, select, counter, synchronizer and output.
- R11: The full 9-bit range is usable: a loaded period of 511 gives markers exactly 511 clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bunch clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one clock per write |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 9 | Write data |
| ext_fid_i | input | 1 | External fiducial, asynchronous |
| fid_o | output | 1 | Selected fiducial, registered |
| status_o | output | 1 | 1 when the external source is routed to `fid_o` |

## Verification
Results appear at three different latencies:
- The select write shows on `status_o` one clock after its edge.
- A load or soft reset clears `fid_o` at its own edge, and the next marker arrives P edges later.
- An external edge reaches `fid_o` two edges after the edge that samples it.

The bench keeps a running edge count and records the edge of each write. It derives every expected value from that count and samples 1 ns after each rising edge, so each check lands on the cycle that the requirement names.

// File: rtl/fid_gen_pkg.sv
package fid_gen_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_HOLD = 2'd0;
  localparam logic [ADDR_W-1:0] A_LOAD = 2'd1;
  localparam logic [ADDR_W-1:0] A_SEL  = 2'd2;
  localparam logic [ADDR_W-1:0] A_SRST = 2'd3;
endpackage

// File: rtl/fid_regs.sv
module fid_regs
  import fid_gen_pkg::*;
#(
  parameter int CNT_W      = 9,
  parameter int DEF_PERIOD = 120
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  hold_o,
  output logic              sel_o,
  output logic              load_o,
  output logic              srst_o
);
  assign srst_o = wr_en_i && (wr_addr_i == A_SRST);
  assign load_o = wr_en_i && (wr_addr_i == A_LOAD) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= CNT_W'(DEF_PERIOD);
      sel_o  <= 1'b0;
    end else if (srst_o) begin
      hold_o <= CNT_W'(DEF_PERIOD);
      sel_o  <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_HOLD) hold_o <= wr_data_i;
      if (wr_addr_i == A_SEL)  sel_o  <= wr_data_i[0];
    end
  end
endmodule

// File: rtl/fid_counter.sv
module fid_counter #(
  parameter int CNT_W      = 9,
  parameter int DEF_PERIOD = 120
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] hold_i,
  output logic             term_o
);
  logic [CNT_W-1:0] active_q, cnt_q;
  logic             degen;

  // periods 0 and 1 pin the marker high
  assign degen  = (active_q <= CNT_W'(1));
  assign term_o = degen || (cnt_q == active_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= CNT_W'(DEF_PERIOD);
      cnt_q    <= '0;
    end else if (clr_i) begin
      active_q <= CNT_W'(DEF_PERIOD);
      cnt_q    <= '0;
    end else if (load_i) begin
      active_q <= hold_i;
      cnt_q    <= '0;
    end else if (term_o) begin
      cnt_q    <= '0;
    end else begin
      cnt_q    <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/fid_sync.sv
module fid_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic nxt;
      if (i == 0) begin : g_first
        assign nxt = d_i;
      end else begin : g_rest
        assign nxt = ff_q[i-1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    ff_q[i] <= 1'b0;
        else if (clr_i) ff_q[i] <= 1'b0;
        else            ff_q[i] <= nxt;
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/fid_gen.sv
module fid_gen
  import fid_gen_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int DEF_PERIOD  = 120,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              ext_fid_i,
  output logic              fid_o,
  output logic              status_o
);
  logic [CNT_W-1:0] hold;
  logic sel, load, srst, term, ext_s, fid_q;

  fid_regs #(.CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .hold_o(hold), .sel_o(sel), .load_o(load), .srst_o(srst)
  );

  fid_counter #(.CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD)) u_cnt (
    .clk_i, .rst_ni, .clr_i(srst), .load_i(load), .hold_i(hold), .term_o(term)
  );

  fid_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .clr_i(srst), .d_i(ext_fid_i), .q_o(ext_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            fid_q <= 1'b0;
    else if (srst || load)  fid_q <= 1'b0;
    else                    fid_q <= sel ? ext_s : term;
  end

  assign fid_o    = fid_q;
  assign status_o = sel;
endmodule

// File: rtl/fid_gen_chk.sv
module fid_gen_chk
  import fid_gen_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [CNT_W-1:0]  wr_data_i,
  input logic              ext_fid_i,
  input logic              fid_o,
  input logic              status_o
);
  logic [1:0] age_q;
  logic       wr_srst, wr_sel, wr_load;

  assign wr_srst = wr_en_i && (wr_addr_i == A_SRST);
  assign wr_sel  = wr_en_i && (wr_addr_i == A_SEL);
  assign wr_load = wr_en_i && (wr_addr_i == A_LOAD) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= '0;
    else if (age_q != 2'd3)   age_q <= age_q + 2'd1;
  end

  assert_srst_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_srst |=> (!fid_o && !status_o));

  assert_sel_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sel |=> (status_o == $past(wr_data_i[0])));

  assert_sel_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_sel || wr_srst) |=> $stable(status_o));

  assert_load_blanks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_load |=> !fid_o);

  assert_ext_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && $past(status_o) && $past(status_o, 2)
     && !$past(wr_load) && !$past(wr_srst)) |-> (fid_o == $past(ext_fid_i, 3)));
endmodule

bind fid_gen fid_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .ext_fid_i(ext_fid_i), .fid_o(fid_o), .status_o(status_o)
);

// File: tb/sim_fid_gen.sv
`timescale 1ns/1ps
module sim_fid_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [8:0] wr_data_i = '0;
  logic       ext_fid_i = 1'b0;
  logic       fid_o, status_o;

  int checks = 0, errors = 0;
  int cyc = 0, base = 0, per = 120;
  bit done = 1'b0;

  fid_gen u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [8:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  function automatic bit exp_int(input int c);
    if (c <= base) return 1'b0;
    if (per <= 1) return 1'b1;
    return ((c - base) % per) == 0;
  endfunction

  task automatic run_int(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #1;
      check(fid_o == exp_int(cyc), req, fid_o, exp_int(cyc));
    end
  endtask

  task automatic do_load(input int p);
    wr(2'd1, 9'd1);
    base = cyc; per = (p == 0) ? 0 : p;
    check(fid_o == 1'b0, "R5", fid_o, 0);
  endtask

  // R1 R2 R3: reset state and default period
  task automatic t_reset();
    #1;
    check(fid_o == 1'b0 && status_o == 1'b0, "R1", {fid_o, status_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1; base = cyc; per = 120;
    check(fid_o == 1'b0 && status_o == 1'b0, "R1", {fid_o, status_o}, 0);
    run_int(245, "R2 R3");
  endtask

  // R10 R4: soft reset then staging write alone
  task automatic t_hold_only();
    wr(2'd3, 9'h1AB);
    base = cyc; per = 120;
    check(fid_o == 1'b0 && status_o == 1'b0, "R10", {fid_o, status_o}, 0);
    wr(2'd0, 9'd10);
    run_int(240, "R4");
  endtask

  // R5 R3 R6
  task automatic t_load();
    do_load(10);
    run_int(20, "R5 R3");
    wr(2'd0, 9'd5);
    check(fid_o == exp_int(cyc), "R6", fid_o, exp_int(cyc));
    wr(2'd1, 9'd0);
    check(fid_o == exp_int(cyc), "R6", fid_o, exp_int(cyc));
    run_int(30, "R6");
  endtask

  // R11
  task automatic t_big();
    wr(2'd0, 9'd511);
    do_load(511);
    run_int(1030, "R11");
  endtask

  // R9
  task automatic t_degen();
    wr(2'd0, 9'd1);
    do_load(1);
    run_int(6, "R9");
    wr(2'd0, 9'd0);
    do_load(0);
    run_int(6, "R9");
    wr(2'd0, 9'd7);
    do_load(7);
    run_int(21, "R3");
  endtask

  // R7 R8
  task automatic t_ext();
    wr(2'd2, 9'd1);
    check(status_o == 1'b1, "R7", status_o, 1);
    repeat (4) begin @(posedge clk_i); #1; check(fid_o == 1'b0, "R7", fid_o, 0); end
    @(negedge clk_i); ext_fid_i = 1'b1;
    @(posedge clk_i); #1; check(fid_o == 1'b0, "R8", fid_o, 0);
    @(negedge clk_i); ext_fid_i = 1'b0;
    @(posedge clk_i); #1; check(fid_o == 1'b0, "R8", fid_o, 0);
    @(posedge clk_i); #1; check(fid_o == 1'b1, "R8", fid_o, 1);
    @(posedge clk_i); #1; check(fid_o == 1'b0, "R8", fid_o, 0);
    @(negedge clk_i); ext_fid_i = 1'b1;
    repeat (3) @(posedge clk_i); #1;
    check(fid_o == 1'b1, "R8", fid_o, 1);
    repeat (5) begin @(posedge clk_i); #1; check(fid_o == 1'b1, "R8", fid_o, 1); end
    wr(2'd2, 9'd0);
    check(status_o == 1'b0, "R7", status_o, 0);
    run_int(14, "R7");
    @(negedge clk_i); ext_fid_i = 1'b0;
  endtask

  // R10: soft reset restores staging period and select
  task automatic t_srst_mid();
    wr(2'd0, 9'd3);
    wr(2'd2, 9'd1);
    wr(2'd3, 9'd0);
    base = cyc; per = 120;
    check(fid_o == 1'b0 && status_o == 1'b0, "R10", {fid_o, status_o}, 0);
    do_load(120);
    run_int(240, "R10");
  endtask

  initial begin
    t_reset();
    t_hold_only();
    t_load();
    t_big();
    t_degen();
    t_ext();
    t_srst_mid();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule